// File: doc/BRIEF.md
# Nested PHY Register Access Sequencer

This block lets a host reach registers inside external PHYs and SerDes lanes that sit behind a switch. It never touches those devices itself. It has only a lower-level word port, which reads and writes 16-bit registers addressed by a 5-bit device number and a 5-bit register number. Inside the global register group at device 0x1c, two of those registers act as a second access window. Register 0x18 carries commands for the remote device. Register 0x19 carries the data that moves with them.

The host presents one request at a time: an operation, a port or PHY number, a register or MMD device number, a 16-bit extended address and write data. The sequencer turns that request into a chain of lower-level transfers. Before every command it polls the busy flag of the command register. A Clause 22 access is a single command. A Clause 45 access is built in two phases: the register address is loaded and latched first, and the read or write follows. When the chain ends, the block returns read data with a one-cycle completion pulse. An error flag is raised instead if the busy flag never clears or if the lower port reports a fault.

Top module: `phyacc_nested`

## Requirements
- R1: Every lower-level transfer addresses device 0x1c, and uses register 0x18 for busy polls and commands and register 0x19 for data loads and data reads.
- R2: Before each command write, the block reads register 0x18 again and again until a read returns bit 15 clear. Only then does it go on.
- R3: If POLL_LIMIT polls in a row return bit 15 set, the request finishes with the error flag set and read data 0. No further lower-level transfer follows.
- R4: Host operation codes are 00 Clause 22 read, 01 Clause 22 write, 10 Clause 45 read and 11 Clause 45 write. A command word has bit 15 set. Bit 12 is set for Clause 22 and clear for Clause 45. Bits 11:10 hold the opcode: Clause 22 read 10, write 01; Clause 45 address 00, write 01, read 11, read-with-increment 10. Bits 9:5 hold the port or PHY number and bits 4:0 hold the register or MMD device number.
- R5: A Clause 22 read issues these transfers in order: poll, read command, poll, then a read of 0x19. The last value is returned as read data.
- R6: A Clause 22 write issues these transfers in order: poll, load of the write data into 0x19, then the write command. It completes with no poll after the command.
- R7: A Clause 45 read issues these transfers in order: poll, load of the 16-bit address into 0x19, address command, poll, read command, poll, then a read of 0x19. The last value is returned as read data.
- R8: A Clause 45 write issues these transfers in order: poll, load of the address into 0x19, address command, poll, load of the write data into 0x19, then the write command. It completes with no trailing poll.
- R9: A transfer that ends with the lower-level error input high aborts the sequence. The request finishes with the error flag set, read data 0, and no further transfer.
- R10: A host request made while the block is busy is ignored. It produces no lower-level transfer.
- R11: Once raised, a lower-level request stays high, and its write flag, register and data stay unchanged, until it is acknowledged.
- R12: After reset, busy, done and the lower-level request are low. Busy is high from the cycle after a request is accepted until completion. Done is a single-cycle pulse, with busy already low. A successful write returns read data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Start a request; accepted only while idle |
| host_op | input | 2 | Operation code (R4) |
| host_port | input | PORT_W | Port or PHY number |
| host_reg | input | REG_W | Register number (Clause 22) or MMD device (Clause 45) |
| host_addr | input | DATA_W | Clause 45 register address |
| host_wdata | input | DATA_W | Write data |
| host_busy | output | 1 | Request in progress |
| host_done | output | 1 | One-cycle completion pulse |
| host_err | output | 1 | Timeout or lower-level error on the last request |
| host_rdata | output | DATA_W | Read result of the last request |
| ll_req | output | 1 | Lower-level transfer request |
| ll_we | output | 1 | Lower-level transfer is a write |
| ll_dev | output | LL_AW | Lower-level device number |
| ll_reg | output | LL_AW | Lower-level register number |
| ll_wdata | output | DATA_W | Lower-level write data |
| ll_ack | input | 1 | Transfer completes in this cycle |
| ll_rdata | input | DATA_W | Lower-level read data, valid with ll_ack |
| ll_err | input | 1 | Lower-level fault, valid with ll_ack |

## Verification
The bench builds the block with POLL_LIMIT set to 5 and keeps the default widths and addresses. With that limit, a timeout takes only a handful of polls. The bench can then drive the busy depth at the last count that still succeeds, one count past it, and every smaller depth in each poll phase of the Clause 45 chains. The full 1600-poll window is not exercised. The same counter logic that finishes at 5 is the one that would finish at 1600.

// File: rtl/phyacc_pkg.sv
// Package: shared types and command field constants for the nested
// PHY access sequencer. Assumes a 16-bit command word.
package phyacc_pkg;

    typedef enum logic [1:0] {
        OP_C22_RD = 2'b00,
        OP_C22_WR = 2'b01,
        OP_C45_RD = 2'b10,
        OP_C45_WR = 2'b11
    } op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_POLL_A,
        ST_LD_ADDR,
        ST_CMD_ADDR,
        ST_POLL_B,
        ST_LD_VAL,
        ST_CMD_OP,
        ST_POLL_C,
        ST_RD_DATA
    } st_e;

    localparam logic [1:0] C22_OPC_RD    = 2'b10;
    localparam logic [1:0] C22_OPC_WR    = 2'b01;
    localparam logic [1:0] C45_OPC_ADDR  = 2'b00;
    localparam logic [1:0] C45_OPC_WR    = 2'b01;
    localparam logic [1:0] C45_OPC_RD    = 2'b11;
    localparam logic [1:0] C45_OPC_RDINC = 2'b10;

    localparam int BUSY_BIT = 15;
    localparam int C22_BIT  = 12;
    localparam int OPC_LSB  = 10;
    localparam int PORT_LSB = 5;

endpackage

// File: rtl/phyacc_cmd_fmt.sv
// Module: builds the command word written to the remote command register.
// Purely combinational. Assumes PORT_LSB + PORT_W <= OPC_LSB and
// REG_W <= PORT_LSB so the fields do not overlap.
module phyacc_cmd_fmt
    import phyacc_pkg::*;
#(
    parameter int PORT_W = 5,
    parameter int REG_W  = 5,
    parameter int DATA_W = 16
) (
    input  op_e               op,
    input  logic              addr_phase,
    input  logic [PORT_W-1:0] port,
    input  logic [REG_W-1:0]  regad,
    output logic [DATA_W-1:0] word
);

    logic [1:0] opc;

    // Select the two-bit opcode for the operation and phase.
    always_comb begin
        unique case (op)
            OP_C22_RD: opc = C22_OPC_RD;
            OP_C22_WR: opc = C22_OPC_WR;
            OP_C45_RD: opc = addr_phase ? C45_OPC_ADDR : C45_OPC_RD;
            default:   opc = addr_phase ? C45_OPC_ADDR : C45_OPC_WR;
        endcase
    end

    // Assemble the fields into the command word.
    always_comb begin
        word = '0;
        word[BUSY_BIT] = 1'b1;
        word[C22_BIT] = ~op[1];
        word[OPC_LSB +: 2] = opc;
        word[PORT_LSB +: PORT_W] = port;
        word[0 +: REG_W] = regad;
    end

endmodule

// File: rtl/phyacc_poll_ctr.sv
// Module: counts consecutive busy polls. It raises at_last on the poll that
// would be the LIMIT-th busy result. Assumes LIMIT >= 1. It wraps to zero
// on that poll so it never holds a value above LIMIT-1.
module phyacc_poll_ctr #(
    parameter int LIMIT = 1600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic bump,
    output logic at_last
);

    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    assign at_last = (cnt == CW'(LIMIT - 1));

    // Track busy polls seen in the current poll phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (bump) begin
            cnt <= at_last ? '0 : cnt + 1'b1;
        end
    end

    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CW'(LIMIT));

endmodule

// File: rtl/phyacc_seq.sv
// Module: the sequencer. It walks a request through the chain of
// lower-level transfers. Assumes the lower port completes a transfer in any
// cycle where ll_req and ll_ack are both high, with ll_rdata and ll_err
// valid in that cycle.
module phyacc_seq
    import phyacc_pkg::*;
#(
    parameter int          PORT_W   = 5,
    parameter int          REG_W    = 5,
    parameter int          DATA_W   = 16,
    parameter int          LL_AW    = 5,
    parameter logic [4:0]  GLB_DEV  = 5'h1c,
    parameter logic [4:0]  CMD_REG  = 5'h18,
    parameter logic [4:0]  DATA_REG = 5'h19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic [1:0]        host_op,
    input  logic [PORT_W-1:0] host_port,
    input  logic [REG_W-1:0]  host_reg,
    input  logic [DATA_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_busy,
    output logic              host_done,
    output logic              host_err,
    output logic [DATA_W-1:0] host_rdata,
    output logic              ll_req,
    output logic              ll_we,
    output logic [LL_AW-1:0]  ll_dev,
    output logic [LL_AW-1:0]  ll_reg,
    output logic [DATA_W-1:0] ll_wdata,
    input  logic              ll_ack,
    input  logic [DATA_W-1:0] ll_rdata,
    input  logic              ll_err,
    input  logic [DATA_W-1:0] cmd_word,
    output op_e               op_q,
    output logic [PORT_W-1:0] port_q,
    output logic [REG_W-1:0]  reg_q,
    output logic              addr_phase,
    input  logic              at_last,
    output logic              poll_clear,
    output logic              poll_bump
);

    st_e               state, nxt;
    logic [DATA_W-1:0] addr_q, wd_q;
    logic              xfer, is_poll, still_busy, fin, fin_err, cap;

    assign xfer       = ll_req && ll_ack;
    assign is_poll    = (state == ST_POLL_A) || (state == ST_POLL_B) || (state == ST_POLL_C);
    assign still_busy = is_poll && ll_rdata[BUSY_BIT];
    assign poll_bump  = xfer && !ll_err && still_busy;
    assign poll_clear = (state == ST_IDLE) || (xfer && !poll_bump);
    assign addr_phase = (state == ST_CMD_ADDR);
    assign host_busy  = (state != ST_IDLE);

    // Choose the next step of the chain from the operation and the transfer result.
    always_comb begin
        nxt = state;
        fin = 1'b0;
        fin_err = 1'b0;
        cap = 1'b0;
        if (state == ST_IDLE) begin
            if (host_req) nxt = ST_POLL_A;
        end else if (xfer) begin
            if (ll_err) begin
                fin = 1'b1;
                fin_err = 1'b1;
            end else if (still_busy) begin
                if (at_last) begin
                    fin = 1'b1;
                    fin_err = 1'b1;
                end
            end else begin
                unique case (state)
                    ST_POLL_A: begin
                        if (op_q == OP_C22_RD)      nxt = ST_CMD_OP;
                        else if (op_q == OP_C22_WR) nxt = ST_LD_VAL;
                        else                        nxt = ST_LD_ADDR;
                    end
                    ST_LD_ADDR:  nxt = ST_CMD_ADDR;
                    ST_CMD_ADDR: nxt = ST_POLL_B;
                    ST_POLL_B:   nxt = (op_q == OP_C45_RD) ? ST_CMD_OP : ST_LD_VAL;
                    ST_LD_VAL:   nxt = ST_CMD_OP;
                    ST_CMD_OP: begin
                        if (op_q[0]) fin = 1'b1;
                        else         nxt = ST_POLL_C;
                    end
                    ST_POLL_C:   nxt = ST_RD_DATA;
                    ST_RD_DATA: begin
                        fin = 1'b1;
                        cap = 1'b1;
                    end
                    default:     nxt = ST_IDLE;
                endcase
            end
            if (fin) nxt = ST_IDLE;
        end
    end

    // Advance the state and latch the request fields on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            op_q   <= OP_C22_RD;
            port_q <= '0;
            reg_q  <= '0;
            addr_q <= '0;
            wd_q   <= '0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && host_req) begin
                op_q   <= op_e'(host_op);
                port_q <= host_port;
                reg_q  <= host_reg;
                addr_q <= host_addr;
                wd_q   <= host_wdata;
            end
        end
    end

    // Register the completion pulse, the error flag and the read result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_done  <= 1'b0;
            host_err   <= 1'b0;
            host_rdata <= '0;
        end else begin
            host_done <= fin;
            if (fin) begin
                host_err   <= fin_err;
                host_rdata <= cap ? ll_rdata : '0;
            end
        end
    end

    // Drive the lower-level transfer from the current step.
    always_comb begin
        ll_req = (state != ST_IDLE);
        ll_dev = LL_AW'(GLB_DEV);
        ll_we  = 1'b0;
        ll_reg = LL_AW'(CMD_REG);
        ll_wdata = '0;
        unique case (state)
            ST_LD_ADDR: begin
                ll_we = 1'b1;
                ll_reg = LL_AW'(DATA_REG);
                ll_wdata = addr_q;
            end
            ST_LD_VAL: begin
                ll_we = 1'b1;
                ll_reg = LL_AW'(DATA_REG);
                ll_wdata = wd_q;
            end
            ST_CMD_ADDR, ST_CMD_OP: begin
                ll_we = 1'b1;
                ll_wdata = cmd_word;
            end
            ST_RD_DATA: ll_reg = LL_AW'(DATA_REG);
            default: ;
        endcase
    end

    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ll_req && !ll_ack |=> ll_req && $stable(ll_we) && $stable(ll_reg) && $stable(ll_wdata));

    assert_err_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        xfer && ll_err |=> host_done && host_err && !ll_req);

    assert_timeout_R3: assert property (@(posedge clk) disable iff (!rst_n)
        poll_bump && at_last |=> host_done && host_err && !ll_req);

    assert_cmd_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ll_req && ll_we && ll_reg == LL_AW'(CMD_REG) |-> ll_wdata[BUSY_BIT] && (ll_wdata[C22_BIT] == !op_q[1]));

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        host_done |-> !host_busy ##1 !host_done);

endmodule

// File: rtl/phyacc_nested.sv
// Module: top of the nested PHY access sequencer. It joins the sequencer,
// the command word builder and the busy-poll counter. Assumes DATA_W is 16
// and that one request is in flight at a time.
module phyacc_nested
    import phyacc_pkg::*;
#(
    parameter int          POLL_LIMIT = 1600,
    parameter int          PORT_W     = 5,
    parameter int          REG_W      = 5,
    parameter int          DATA_W     = 16,
    parameter int          LL_AW      = 5,
    parameter logic [4:0]  GLB_DEV    = 5'h1c,
    parameter logic [4:0]  CMD_REG    = 5'h18,
    parameter logic [4:0]  DATA_REG   = 5'h19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic [1:0]        host_op,
    input  logic [PORT_W-1:0] host_port,
    input  logic [REG_W-1:0]  host_reg,
    input  logic [DATA_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_busy,
    output logic              host_done,
    output logic              host_err,
    output logic [DATA_W-1:0] host_rdata,
    output logic              ll_req,
    output logic              ll_we,
    output logic [LL_AW-1:0]  ll_dev,
    output logic [LL_AW-1:0]  ll_reg,
    output logic [DATA_W-1:0] ll_wdata,
    input  logic              ll_ack,
    input  logic [DATA_W-1:0] ll_rdata,
    input  logic              ll_err
);

    op_e               op_q;
    logic [PORT_W-1:0] port_q;
    logic [REG_W-1:0]  reg_q;
    logic              addr_phase, at_last, poll_clear, poll_bump;
    logic [DATA_W-1:0] cmd_word;

    phyacc_cmd_fmt #(
        .PORT_W(PORT_W), .REG_W(REG_W), .DATA_W(DATA_W)
    ) u_fmt (
        .op(op_q), .addr_phase(addr_phase), .port(port_q), .regad(reg_q), .word(cmd_word)
    );

    phyacc_poll_ctr #(.LIMIT(POLL_LIMIT)) u_ctr (
        .clk(clk), .rst_n(rst_n), .clear(poll_clear), .bump(poll_bump), .at_last(at_last)
    );

    phyacc_seq #(
        .PORT_W(PORT_W), .REG_W(REG_W), .DATA_W(DATA_W), .LL_AW(LL_AW),
        .GLB_DEV(GLB_DEV), .CMD_REG(CMD_REG), .DATA_REG(DATA_REG)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .host_req(host_req), .host_op(host_op), .host_port(host_port), .host_reg(host_reg),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_busy(host_busy), .host_done(host_done), .host_err(host_err), .host_rdata(host_rdata),
        .ll_req(ll_req), .ll_we(ll_we), .ll_dev(ll_dev), .ll_reg(ll_reg), .ll_wdata(ll_wdata),
        .ll_ack(ll_ack), .ll_rdata(ll_rdata), .ll_err(ll_err),
        .cmd_word(cmd_word), .op_q(op_q), .port_q(port_q), .reg_q(reg_q),
        .addr_phase(addr_phase), .at_last(at_last), .poll_clear(poll_clear), .poll_bump(poll_bump)
    );

endmodule

// File: tb/phyacc_nested_test.sv
`timescale 1ns/1ps
// Bench: a lower-level responder model with a busy countdown and error
// injection. Mixed directed and seeded random requests; the lower-level
// transfer log is compared with a sequence the bench builds on its own.
module phyacc_nested_test;

    localparam int LIMIT = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic [1:0]  host_op = '0;
    logic [4:0]  host_port = '0, host_reg = '0;
    logic [15:0] host_addr = '0, host_wdata = '0;
    logic        host_busy, host_done, host_err;
    logic [15:0] host_rdata;
    logic        ll_req, ll_we;
    logic [4:0]  ll_dev, ll_reg;
    logic [15:0] ll_wdata;
    logic        ll_ack = 1'b0, ll_err = 1'b0;
    logic [15:0] ll_rdata = '0;

    phyacc_nested #(.POLL_LIMIT(LIMIT)) uut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_op(host_op),
        .host_port(host_port), .host_reg(host_reg), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_busy(host_busy), .host_done(host_done), .host_err(host_err), .host_rdata(host_rdata),
        .ll_req(ll_req), .ll_we(ll_we), .ll_dev(ll_dev), .ll_reg(ll_reg), .ll_wdata(ll_wdata),
        .ll_ack(ll_ack), .ll_rdata(ll_rdata), .ll_err(ll_err)
    );

    always #4 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    logic [21:0] log_q [0:63];
    int log_n = 0, dev_bad = 0;
    logic [21:0] exp_q [0:63];
    int exp_n = 0;
    int busy_cfg = 0, busy_left = 0, err_at = -1;
    logic [15:0] rd_val = '0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    function automatic logic [15:0] cmdw(input bit c22, input logic [1:0] opc,
                                         input logic [4:0] p, input logic [4:0] r);
        return 16'h8000 | (c22 ? 16'h1000 : 16'h0) | (16'(opc) << 10) | (16'(p) << 5) | 16'(r);
    endfunction

    bit aborted;
    bit exp_e;

    task automatic push(input logic [21:0] e);
        if (aborted) return;
        exp_q[exp_n] = e;
        exp_n++;
        if (exp_n - 1 == err_at) begin aborted = 1; exp_e = 1; end
    endtask

    task automatic poll_phase();
        int n;
        n = (busy_cfg < LIMIT) ? busy_cfg + 1 : LIMIT;
        for (int i = 0; i < n; i++) push({1'b0, 5'h18, 16'h0});
        if (busy_cfg >= LIMIT && !aborted) begin aborted = 1; exp_e = 1; end
    endtask

    // Expected transfer chain built from R5..R8 with the polls of R2 and aborts of R3/R9.
    task automatic build_exp(input logic [1:0] op, input logic [4:0] p, input logic [4:0] r,
                             input logic [15:0] a, input logic [15:0] w);
        exp_n = 0; aborted = 0; exp_e = 0;
        poll_phase();
        case (op)
            2'b00: begin
                push({1'b1, 5'h18, cmdw(1, 2'b10, p, r)});
                poll_phase();
                push({1'b0, 5'h19, 16'h0});
            end
            2'b01: begin
                push({1'b1, 5'h19, w});
                push({1'b1, 5'h18, cmdw(1, 2'b01, p, r)});
            end
            2'b10: begin
                push({1'b1, 5'h19, a});
                push({1'b1, 5'h18, cmdw(0, 2'b00, p, r)});
                poll_phase();
                push({1'b1, 5'h18, cmdw(0, 2'b11, p, r)});
                poll_phase();
                push({1'b0, 5'h19, 16'h0});
            end
            default: begin
                push({1'b1, 5'h19, a});
                push({1'b1, 5'h18, cmdw(0, 2'b00, p, r)});
                poll_phase();
                push({1'b1, 5'h19, w});
                push({1'b1, 5'h18, cmdw(0, 2'b01, p, r)});
            end
        endcase
    endtask

    // Lower-level responder: random ack delay, busy countdown, error injection.
    initial begin
        int wait_cnt;
        wait_cnt = 0;
        forever begin
            @(negedge clk);
            ll_ack = 1'b0;
            ll_err = 1'b0;
            if (rst_n && ll_req) begin
                if (wait_cnt > 0) begin
                    wait_cnt--;
                end else begin
                    ll_ack = 1'b1;
                    if (ll_dev != 5'h1c) dev_bad++;
                    if (log_n < 64) log_q[log_n] = {ll_we, ll_reg, ll_we ? ll_wdata : 16'h0};
                    if (log_n == err_at) ll_err = 1'b1;
                    log_n++;
                    if (!ll_we && ll_reg == 5'h18) begin
                        if (busy_left > 0) begin
                            ll_rdata = 16'h8000 | 16'($urandom & 32'h7fff);
                            busy_left--;
                        end else begin
                            ll_rdata = 16'($urandom & 32'h7fff);
                        end
                    end else if (!ll_we) begin
                        ll_rdata = rd_val;
                    end else begin
                        ll_rdata = 16'($urandom);
                        if (ll_reg == 5'h18) busy_left = busy_cfg;
                    end
                    wait_cnt = $urandom % 3;
                end
            end
        end
    end

    task automatic run_op(input logic [1:0] op, input logic [4:0] p, input logic [4:0] r,
                          input logic [15:0] a, input logic [15:0] w, input int bcfg,
                          input int eat, input logic [15:0] rv, input bit poke);
        string tag;
        int cyc, n_at_done;
        bit seq_ok;
        busy_cfg = bcfg;
        err_at = eat;
        build_exp(op, p, r, a, w);
        busy_left = bcfg;
        rd_val = rv;
        log_n = 0;
        dev_bad = 0;
        case (op)
            2'b00: tag = "R5 R2 R4";
            2'b01: tag = "R6 R2 R4";
            2'b10: tag = "R7 R2 R4";
            default: tag = "R8 R2 R4";
        endcase
        @(negedge clk);
        host_req = 1'b1; host_op = op; host_port = p; host_reg = r; host_addr = a; host_wdata = w;
        @(negedge clk);
        host_req = 1'b0;
        chk(host_busy === 1'b1, "R12", "busy after accept", 32'(host_busy), 1);
        if (poke) begin
            // R10: a second request while busy must change nothing.
            host_req = 1'b1; host_op = ~op; host_port = ~p; host_reg = ~r; host_addr = ~a; host_wdata = ~w;
            @(negedge clk);
            host_req = 1'b0;
        end
        cyc = 0;
        while (host_done !== 1'b1 && cyc < 3000) begin
            @(negedge clk);
            cyc++;
        end
        chk(host_done === 1'b1, "R12", "done seen", 32'(host_done), 1);
        chk(host_busy === 1'b0, "R12", "busy low with done", 32'(host_busy), 0);
        chk(host_err === exp_e, exp_e ? "R3 R9" : tag, "error flag", 32'(host_err), 32'(exp_e));
        chk(host_rdata === ((!op[0] && !exp_e) ? rv : 16'h0), (op[0] && !exp_e) ? "R12" : tag,
            "read data", 32'(host_rdata), 32'((!op[0] && !exp_e) ? rv : 16'h0));
        seq_ok = (log_n == exp_n);
        for (int i = 0; i < exp_n && i < 64; i++) if (log_q[i] !== exp_q[i]) seq_ok = 0;
        chk(seq_ok, poke ? "R10" : tag, "transfer chain (count)", 32'(log_n), 32'(exp_n));
        chk(dev_bad == 0, "R1", "device number mismatches", 32'(dev_bad), 0);
        n_at_done = log_n;
        @(negedge clk);
        chk(host_done === 1'b0, "R12", "done one cycle", 32'(host_done), 0);
        repeat (4) @(negedge clk);
        chk(log_n == n_at_done && !host_busy, exp_e ? "R3 R9" : "R10", "no transfer after done",
            32'(log_n), 32'(n_at_done));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!host_busy && !host_done && !ll_req, "R12", "reset state",
            {29'd0, host_busy, host_done, ll_req}, 0);
        // Directed cases.
        run_op(2'b00, 5'd3,  5'd1,  16'h0000, 16'h0000, 0, -1, 16'h1234, 0);
        run_op(2'b01, 5'd31, 5'd0,  16'h0000, 16'hbeef, 2, -1, 16'h0,    0);
        run_op(2'b10, 5'd17, 5'd4,  16'h2000, 16'h0000, 1, -1, 16'hc0de, 0);
        run_op(2'b11, 5'd18, 5'd4,  16'h2000, 16'h1140, 1, -1, 16'h0,    0);
        run_op(2'b10, 5'd9,  5'd7,  16'hffff, 16'h0000, LIMIT - 1, -1, 16'h5a5a, 0);
        run_op(2'b00, 5'd1,  5'd2,  16'h0000, 16'h0000, LIMIT, -1, 16'h7777, 0);   // R3 timeout
        run_op(2'b10, 5'd2,  5'd30, 16'h00aa, 16'h0000, 0, 3, 16'h4444, 0);        // R9 on a poll
        run_op(2'b01, 5'd5,  5'd5,  16'h0000, 16'h0f0f, 0, 1, 16'h0, 0);           // R9 on data load
        run_op(2'b11, 5'd6,  5'd3,  16'h8001, 16'h7e7e, 1, -1, 16'h0, 1);          // R10 poke
        // Seeded random requests.
        for (int k = 0; k < 40; k++) begin
            run_op(2'($urandom), 5'($urandom), 5'($urandom), 16'($urandom), 16'($urandom),
                   int'($urandom % 4), ($urandom % 8 == 0) ? int'($urandom % 4) : -1,
                   16'($urandom), ($urandom % 6 == 0));
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule